// File: doc/BRIEF.md
# MII Receive Nibble-to-Byte Assembler

This block sits on the MAC side of a media-independent receive path. On every rising edge of the receive clock it samples the 4-bit data bus, the data-valid strobe and the error strobe. It finds the start of each frame by hunting through the preamble for the start-frame delimiter. It then pairs the nibbles that follow into bytes and sends out a byte stream, with a first-byte marker and a last-byte marker. The last-byte marker carries the frame status: a sticky receive-error flag, an alignment-error flag and a saturating byte count. The logic is the same at 10 Mb/s and at 100 Mb/s, because only the clock rate differs between them.

When data-valid is low, the error strobe together with the code 1110 on the data bus is a false-carrier indication. The block reports it on a separate one-cycle pulse output that does not depend on any frame. CRC checking, address filtering and any clock-domain crossing to the MAC core are outside this block.

The byte count is `LEN_W` bits wide and stops at its all-ones value. Each byte is held back until the next byte completes or data-valid drops, so the last-byte marker can come out together with the last byte.

Top module: `mii_rx_assembler`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, every output is 0.
- R2: A data nibble is taken only in a cycle with `rxDv` high. The first nibble after the delimiter is bits [3:0] of a byte and the next nibble is bits [7:4]. A completed byte that is not the last one appears on `outData` with `outValid` high for exactly one cycle. That cycle is the one right after the clock edge that samples the high nibble of the following byte.
- R3: Preamble nibbles are 4'h5, and the delimiter is nibble 4'h5 followed by nibble 4'hD. `rxDv` may rise on any preamble nibble, up to and including the delimiter's 4'h5. If the first nibble with `rxDv` high is not 4'h5, or if a nibble other than 4'h5 or 4'hD appears before the delimiter, the whole frame produces no output until `rxDv` goes low.
- R4: While `rxDv` is low, `rxd` has no effect on the byte stream. Two consecutive samples with `rxDv` low are followed by a cycle with `outValid` low.
- R5: `outStart` is high together with the first byte of a frame. `outEnd` is high together with its last byte. The last byte appears in the cycle after the first clock edge that samples `rxDv` low.
- R6: If `rxEr` is high in any cycle with `rxDv` high, from the first preamble nibble to the last data nibble, then `outErr` is high together with `outEnd`. Otherwise `outErr` is low. `outErr` is never high without `outEnd`.
- R7: If `rxDv` falls after an odd number of data nibbles, the leftover nibble is discarded and `outAlignErr` is high together with `outEnd`. Otherwise `outAlignErr` is low.
- R8: Together with `outEnd`, `outLen` gives the number of bytes sent out in the frame, including the last one, limited to 2^LEN_W-1. In all other cycles `outLen` is 0.
- R9: `falseCarrier` is high in the cycle after each clock edge that samples `rxDv`=0, `rxEr`=1 and `rxd`=4'hE, and low after every other edge. It is never raised by a sample with `rxDv` high.
- R10: A frame that ends before a complete byte follows the delimiter produces no output at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock (25 MHz or 2.5 MHz) |
| rstN | input | 1 | Synchronous active-low reset |
| rxDv | input | 1 | Receive data valid |
| rxEr | input | 1 | Receive error strobe |
| rxd | input | 4 | Receive data nibble |
| outValid | output | 1 | Byte strobe |
| outData | output | 8 | Assembled byte |
| outStart | output | 1 | First byte of a frame |
| outEnd | output | 1 | Last byte of a frame; status below is valid |
| outErr | output | 1 | Receive error seen in the frame |
| outAlignErr | output | 1 | Frame ended on an odd nibble |
| outLen | output | LEN_W | Frame byte count, saturating |
| falseCarrier | output | 1 | One-cycle false-carrier pulse |

## Verification
The bench builds the block with `LEN_W` = 6, so the byte count saturates at 63. A 70-byte frame therefore reaches the clamp in a short run, and a 6-byte frame shows the normal count. At that width every preamble variant, delimiter failure, odd tail, error placement and false-carrier pattern fits in a few hundred cycles, and all of them are compared against a behavioural nibble-queue model on every cycle.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LO,
    ST_HI,
    ST_DROP
  } rxState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearFrame;
    logic markErr;
    logic holdLow;
    logic formByte;
    logic finish;
    logic alignBad;
  } rxCtrl_t;

  localparam logic [3:0] NIB_PREAMBLE = 4'h5;
  localparam logic [3:0] NIB_SFD_HIGH = 4'hD;
  localparam logic [3:0] NIB_FALSE_CARRIER = 4'hE;

endpackage

// File: rtl/mii_rx_ctrl.sv
module mii_rx_ctrl
  import mii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxDv,
  input  logic       rxEr,
  input  logic [3:0] rxd,
  output rxCtrl_t    ctrl
);

  rxState_e state;
  rxState_e nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (rxDv) begin
          ctrl.clearFrame = 1'b1;
          ctrl.markErr    = rxEr;
          nextState       = (rxd == NIB_PREAMBLE) ? ST_PRE : ST_DROP;
        end
      end
      ST_PRE: begin
        if (!rxDv) begin
          nextState = ST_IDLE;
        end else begin
          ctrl.markErr = rxEr;
          if (rxd == NIB_SFD_HIGH)      nextState = ST_LO;
          else if (rxd != NIB_PREAMBLE) nextState = ST_DROP;
        end
      end
      ST_LO: begin
        if (rxDv) begin
          ctrl.holdLow = 1'b1;
          ctrl.markErr = rxEr;
          nextState    = ST_HI;
        end else begin
          ctrl.finish  = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      ST_HI: begin
        if (rxDv) begin
          ctrl.formByte = 1'b1;
          ctrl.markErr  = rxEr;
          nextState     = ST_LO;
        end else begin
          ctrl.finish   = 1'b1;
          ctrl.alignBad = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (!rxDv) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/mii_rx_dp.sv
module mii_rx_dp
  import mii_rx_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxCtrl_t          ctrl,
  input  logic             rxDv,
  input  logic             rxEr,
  input  logic [3:0]       rxd,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outStart,
  output logic             outEnd,
  output logic             outErr,
  output logic             outAlignErr,
  output logic [LEN_W-1:0] outLen,
  output logic             falseCarrier
);

  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [3:0]       lowNib;
  logic [7:0]       pendByte;
  logic             pendValid;
  logic             sentAny;
  logic             errSticky;
  logic [LEN_W-1:0] byteCnt;
  logic [LEN_W-1:0] cntNext;

  assign cntNext = (byteCnt == LEN_MAX) ? byteCnt : byteCnt + LEN_ONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowNib       <= '0;
      pendByte     <= '0;
      pendValid    <= 1'b0;
      sentAny      <= 1'b0;
      errSticky    <= 1'b0;
      byteCnt      <= '0;
      outValid     <= 1'b0;
      outData      <= '0;
      outStart     <= 1'b0;
      outEnd       <= 1'b0;
      outErr       <= 1'b0;
      outAlignErr  <= 1'b0;
      outLen       <= '0;
      falseCarrier <= 1'b0;
    end else begin
      outValid     <= 1'b0;
      outStart     <= 1'b0;
      outEnd       <= 1'b0;
      outErr       <= 1'b0;
      outAlignErr  <= 1'b0;
      outLen       <= '0;
      falseCarrier <= !rxDv && rxEr && (rxd == NIB_FALSE_CARRIER);

      if (ctrl.clearFrame) begin
        pendValid <= 1'b0;
        sentAny   <= 1'b0;
        byteCnt   <= '0;
        errSticky <= ctrl.markErr;
      end else if (ctrl.markErr) begin
        errSticky <= 1'b1;
      end

      if (ctrl.holdLow) lowNib <= rxd;

      if (ctrl.formByte) begin
        pendByte  <= {rxd, lowNib};
        pendValid <= 1'b1;
        if (pendValid) begin
          outValid <= 1'b1;
          outData  <= pendByte;
          outStart <= !sentAny;
          sentAny  <= 1'b1;
          byteCnt  <= cntNext;
        end
      end

      if (ctrl.finish) begin
        pendValid <= 1'b0;
        if (pendValid) begin
          outValid    <= 1'b1;
          outData     <= pendByte;
          outStart    <= !sentAny;
          outEnd      <= 1'b1;
          outErr      <= errSticky;
          outAlignErr <= ctrl.alignBad;
          outLen      <= cntNext;
        end
      end
    end
  end

endmodule

// File: rtl/mii_rx_assembler.sv
module mii_rx_assembler
  import mii_rx_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxDv,
  input  logic             rxEr,
  input  logic [3:0]       rxd,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outStart,
  output logic             outEnd,
  output logic             outErr,
  output logic             outAlignErr,
  output logic [LEN_W-1:0] outLen,
  output logic             falseCarrier
);

  rxCtrl_t ctrl;

  mii_rx_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .rxDv (rxDv),
    .rxEr (rxEr),
    .rxd  (rxd),
    .ctrl (ctrl)
  );

  mii_rx_dp #(.LEN_W(LEN_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .rxDv         (rxDv),
    .rxEr         (rxEr),
    .rxd          (rxd),
    .outValid     (outValid),
    .outData      (outData),
    .outStart     (outStart),
    .outEnd       (outEnd),
    .outErr       (outErr),
    .outAlignErr  (outAlignErr),
    .outLen       (outLen),
    .falseCarrier (falseCarrier)
  );

endmodule

// File: rtl/mii_rx_checks.sv
module mii_rx_checks #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxDv,
  input logic             rxEr,
  input logic [3:0]       rxd,
  input logic             outValid,
  input logic             outStart,
  input logic             outEnd,
  input logic             outErr,
  input logic             outAlignErr,
  input logic [LEN_W-1:0] outLen,
  input logic             falseCarrier
);

  a_r5_start_has_byte: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> outValid);

  a_r5_end_has_byte: assert property (@(posedge clk) disable iff (!rstN)
    outEnd |-> outValid);

  a_r6_err_only_at_end: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> outEnd);

  a_r7_align_only_at_end: assert property (@(posedge clk) disable iff (!rstN)
    outAlignErr |-> outEnd);

  a_r8_len_only_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (outLen != '0) |-> outEnd);

  a_r8_len_nonzero_at_end: assert property (@(posedge clk) disable iff (!rstN)
    outEnd |-> (outLen != '0));

  a_r9_false_carrier_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (!rxDv && rxEr && rxd == 4'hE) |=> falseCarrier);

  a_r9_no_fc_inside_frame: assert property (@(posedge clk) disable iff (!rstN)
    rxDv |=> !falseCarrier);

  a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!rxDv && $past(!rxDv)) |=> !outValid);

endmodule

bind mii_rx_assembler mii_rx_checks #(.LEN_W(LEN_W)) u_checks (
  .clk          (clk),
  .rstN         (rstN),
  .rxDv         (rxDv),
  .rxEr         (rxEr),
  .rxd          (rxd),
  .outValid     (outValid),
  .outStart     (outStart),
  .outEnd       (outEnd),
  .outErr       (outErr),
  .outAlignErr  (outAlignErr),
  .outLen       (outLen),
  .falseCarrier (falseCarrier)
);

// File: tb/mii_rx_assembler_bench.sv
module mii_rx_assembler_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 6;
  localparam int LEN_CAP = (1 << LW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxDv = 1'b0;
  logic          rxEr = 1'b0;
  logic [3:0]    rxd = 4'h0;
  logic          outValid, outStart, outEnd, outErr, outAlignErr, falseCarrier;
  logic [7:0]    outData;
  logic [LW-1:0] outLen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mii_rx_assembler #(.LEN_W(LW)) u_mii_rx_assembler (
    .clk(clk), .rstN(rstN), .rxDv(rxDv), .rxEr(rxEr), .rxd(rxd),
    .outValid(outValid), .outData(outData), .outStart(outStart),
    .outEnd(outEnd), .outErr(outErr), .outAlignErr(outAlignErr),
    .outLen(outLen), .falseCarrier(falseCarrier)
  );

  // ---------------- behavioural reference model ----------------
  int         mMode = 0;   // 0 idle, 1 preamble, 2 data, 3 discard
  logic [3:0] nibs[$];
  bit         mErr = 0;
  int         mSent = 0;
  bit         expValid = 0, expStart = 0, expEnd = 0, expErr = 0, expAlign = 0, expFc = 0;
  logic [7:0] expData = 8'h00;
  int         expLen = 0;

  task automatic emit(input int k, input bit last, input bit odd);
    expValid = 1;
    expData  = {nibs[2*k+1], nibs[2*k]};
    expStart = (mSent == 0);
    mSent++;
    if (last) begin
      expEnd   = 1;
      expErr   = mErr;
      expAlign = odd;
      expLen   = (mSent > LEN_CAP) ? LEN_CAP : mSent;
    end
  endtask

  always @(posedge clk) begin
    expValid = 0; expStart = 0; expEnd = 0; expErr = 0; expAlign = 0; expLen = 0;
    if (!rstN) begin
      mMode = 0; nibs.delete(); expFc = 0;
    end else begin
      expFc = !rxDv && rxEr && (rxd == 4'hE);
      case (mMode)
        0: if (rxDv) begin
             nibs.delete(); mErr = rxEr; mSent = 0;
             mMode = (rxd == 4'h5) ? 1 : 3;
           end
        1: if (!rxDv) mMode = 0;
           else begin
             if (rxEr) mErr = 1;
             if (rxd == 4'hD) mMode = 2;
             else if (rxd != 4'h5) mMode = 3;
           end
        2: if (rxDv) begin
             if (rxEr) mErr = 1;
             nibs.push_back(rxd);
             if (nibs.size() % 2 == 0 && nibs.size() >= 4)
               emit(nibs.size()/2 - 2, 0, 0);
           end else begin
             if (nibs.size() >= 2) emit(nibs.size()/2 - 1, 1, nibs.size() % 2);
             mMode = 0;
           end
        default: if (!rxDv) mMode = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  int seenBytes = 0, seenEnds = 0, seenErr = 0, seenAlign = 0, seenFc = 0, lastLen = 0;

  task automatic cmp(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      cmp(outValid == expValid, "R2", "outValid", outValid, expValid);
      if (expValid) cmp(outData == expData, "R2", "outData", outData, expData);
      cmp(outStart == expStart, "R5", "outStart", outStart, expStart);
      cmp(outEnd == expEnd, "R5", "outEnd", outEnd, expEnd);
      cmp(outErr == expErr, "R6", "outErr", outErr, expErr);
      cmp(outAlignErr == expAlign, "R7", "outAlignErr", outAlignErr, expAlign);
      cmp(int'(outLen) == expLen, "R8", "outLen", outLen, expLen);
      cmp(falseCarrier == expFc, "R9", "falseCarrier", falseCarrier, expFc);
      if (outValid) seenBytes++;
      if (outEnd) begin seenEnds++; lastLen = outLen; end
      if (outErr) seenErr++;
      if (outAlignErr) seenAlign++;
      if (falseCarrier) seenFc++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic nib(input bit v, input bit e, input logic [3:0] x);
    rxDv = v; rxEr = e; rxd = x;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) nib(0, 0, 4'h0);
  endtask

  task automatic clearSeen();
    seenBytes = 0; seenEnds = 0; seenErr = 0; seenAlign = 0; seenFc = 0; lastLen = 0;
  endtask

  task automatic frame(input int preNibs, input int nBytes, input logic [7:0] seed,
                       input int errAt, input bit oddTail);
    logic [7:0] b;
    for (int i = 0; i < preNibs; i++) nib(1, 0, 4'h5);
    nib(1, 0, 4'hD);
    for (int i = 0; i < nBytes; i++) begin
      b = seed + 8'(i * 37);
      nib(1, errAt == i, b[3:0]);
      nib(1, 0, b[7:4]);
    end
    if (oddTail) nib(1, 0, 4'h9);
    idle(4);
  endtask

  initial begin
    @(negedge clk);
    idle(3);
    cmp(!outValid && !outStart && !outEnd && !outErr && !outAlignErr && outLen == 0 && !falseCarrier,
        "R1", "outputs in reset", {outValid, outEnd, falseCarrier}, 0);
    rstN = 1'b1;
    @(negedge clk);
    cmp(!outValid && !outEnd && !falseCarrier, "R1", "outputs after reset", {outValid, outEnd, falseCarrier}, 0);

    clearSeen(); frame(15, 6, 8'h11, -1, 0);
    cmp(seenBytes == 6, "R2", "bytes in normal frame", seenBytes, 6);
    cmp(seenEnds == 1, "R5", "end markers", seenEnds, 1);
    cmp(lastLen == 6, "R8", "frame length", lastLen, 6);

    clearSeen(); frame(2, 3, 8'hA0, -1, 0);
    cmp(seenBytes == 3, "R3", "late data-valid bytes", seenBytes, 3);

    clearSeen(); frame(1, 1, 8'h3C, -1, 0);
    cmp(seenBytes == 1 && seenEnds == 1, "R5", "single byte frame", seenBytes, 1);

    clearSeen(); frame(7, 5, 8'h5A, 2, 0);
    cmp(seenErr == 1, "R6", "receive error reported", seenErr, 1);

    clearSeen(); frame(7, 4, 8'hF0, -1, 1);
    cmp(seenBytes == 4 && seenAlign == 1, "R7", "odd tail alignment", seenAlign, 1);

    clearSeen();
    for (int i = 0; i < 6; i++) nib(1, 0, 4'h5);
    nib(1, 0, 4'h3); nib(1, 0, 4'h5); nib(1, 0, 4'hD);
    for (int i = 0; i < 8; i++) nib(1, 0, 4'(i));
    idle(4);
    cmp(seenBytes == 0, "R3", "bad preamble nibble dropped", seenBytes, 0);

    clearSeen();
    nib(1, 0, 4'hD);
    for (int i = 0; i < 8; i++) nib(1, 0, 4'hA);
    idle(4);
    cmp(seenBytes == 0, "R3", "frame opening on D dropped", seenBytes, 0);

    clearSeen(); frame(5, 0, 8'h00, -1, 0); frame(5, 0, 8'h00, -1, 1);
    cmp(seenBytes == 0 && seenEnds == 0, "R10", "no complete byte", seenBytes, 0);

    clearSeen();
    for (int i = 0; i < 20; i++) nib(0, 0, 4'(i * 5));
    cmp(seenBytes == 0 && seenFc == 0, "R4", "idle nibbles ignored", seenBytes, 0);

    clearSeen();
    nib(0, 1, 4'hE); nib(0, 1, 4'hE); nib(0, 1, 4'hF); nib(0, 0, 4'hE);
    nib(0, 1, 4'hE); idle(3);
    cmp(seenFc == 3, "R9", "false carrier pulses", seenFc, 3);
    clearSeen();
    for (int i = 0; i < 3; i++) nib(1, 0, 4'h5);
    nib(1, 0, 4'hD); nib(1, 1, 4'hE); nib(1, 1, 4'hE); idle(4);
    cmp(seenFc == 0 && seenErr == 1, "R9", "no false carrier with data-valid", seenFc, 0);

    clearSeen(); frame(15, 70, 8'h07, -1, 0);
    cmp(seenBytes == 70, "R2", "long frame bytes", seenBytes, 70);
    cmp(lastLen == LEN_CAP, "R8", "saturated length", lastLen, LEN_CAP);

    clearSeen(); frame(3, 2, 8'hC3, 0, 1);
    cmp(seenErr == 1 && seenAlign == 1 && lastLen == 2, "R7", "error and odd tail", lastLen, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t: actual running expected finished", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule